// File: doc/BRIEF.md
# Flash Write Status Generator

This block is the device-side logic that builds the status word a NOR-style flash returns while an internal program or erase runs. It follows the operation mode: idle, programming, erasing, erase suspended, programming while erase is suspended, and two short lockout timeouts for writes aimed at protected sectors. It also keeps a sticky failure flag and a per-sector mask of the sectors being erased. Start pulses are taken to arrive on the rising edge of the final write pulse of a command sequence, so the new status is visible from the next clock.

Each read strobe returns one status word. Two toggle bits invert from one read to the next, not from one clock to the next. Bit 6 reports whether an embedded operation is running. Bit 2 reports whether the addressed sector is one of those chosen for erase. Read together, the two bits give both the mode and the sector. A timeout bit shows that the internal pulse limit was exceeded. An open-drain ready/busy line is modelled as a pull-low enable plus a resolved level.

When no operation is running and the addressed sector is not suspended mid-erase, a read returns the array word presented on an input port.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is idle. `rb_pull_low` is 0, `rb_level` is 1, and every read returns `array_word`.
- R2: The status word has bit 6 as toggle I, bit 5 as failure, bit 2 as toggle II, and all other bits 0. While a program or erase is active, bit 6 inverts on each read strobe at any address. After `op_done` it stops inverting and reads return `array_word`.
- R3: In erase suspend, bit 6 keeps its value across reads. A program started during suspend makes bit 6 invert and drives busy. Its `op_done` returns the block to suspend.
- R4: Bit 2 inverts on a read only when the sector field `rd_addr[ADDR_W-1 -: log2(NSECT)]` selects a sector chosen for erase, both while erasing and while suspended. In suspend, a read of a sector not chosen for erase returns `array_word`.
- R5: `limit_hit` during a program or erase sets bit 5 to 1. The operation then stays busy and ignores `op_done` until `reset_cmd`.
- R6: A program whose address lies in a protected sector keeps the block busy for exactly `PROG_PROT_CYC` clocks after the start edge, then returns to the previous idle or suspend state.
- R7: An erase whose selected sectors are all protected keeps the block busy for exactly `ERASE_PROT_CYC` clocks, then returns to idle.
- R8: In a mixed erase selection, protected sectors are left out of the erase mask, so bit 2 does not invert when such a sector is read.
- R9: `rb_pull_low` is 1 while programming or erasing, including during the lockout timeouts and a program in suspend. It is 0 when idle or erase-suspended. `rb_level` is always its inverse.
- R10: A start pulse changes the state on the clock edge that samples it. Busy is visible in the following cycle.
- R11: `reset_cmd` returns the block to idle from any state and clears the failure flag and the erase mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_go | input | 1 | Program start pulse |
| prog_addr | input | ADDR_W | Program target address |
| erase_go | input | 1 | Erase start pulse |
| erase_sel | input | NSECT | Sectors chosen for erase |
| suspend_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| prot_mask | input | NSECT | Protected sectors |
| op_done | input | 1 | Internal operation complete |
| limit_hit | input | 1 | Internal pulse count limit exceeded |
| reset_cmd | input | 1 | Reset command |
| rd_stb | input | 1 | Read strobe, one per read |
| rd_addr | input | ADDR_W | Read address |
| array_word | input | DW | Placeholder array data |
| rd_data | output | DW | Read data or status word |
| rb_pull_low | output | 1 | Open-drain enable, 1 pulls the line low |
| rb_level | output | 1 | Resolved ready/busy level |

## Verification
The hardest state to reach from the ports is a program that runs while an erase is suspended. It needs an erase with a non-empty unprotected mask, a suspend accepted with no failure pending, and a program to an unprotected address. Only then can the bench show bit 6 inverting while bit 2 still inverts for the suspended sectors and holds still elsewhere. Directed sequences walk this path first. A seeded random walk then picks actions according to the bench's own mode model, so it keeps returning to suspend and to suspended programs with failures and reset commands mixed in.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int NSECT          = 8,
  parameter int ADDR_W         = 8,
  parameter int DW             = 8,
  parameter int CLK_MHZ        = 50,
  parameter int PROG_PROT_CYC  = 2 * CLK_MHZ,
  parameter int ERASE_PROT_CYC = 100 * CLK_MHZ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_go,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              erase_go,
  input  logic [NSECT-1:0]  erase_sel,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              op_done,
  input  logic              limit_hit,
  input  logic              reset_cmd,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     array_word,
  output logic [DW-1:0]     rd_data,
  output logic              rb_pull_low,
  output logic              rb_level
);

  localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1;
  localparam int TMAX   = (ERASE_PROT_CYC > PROG_PROT_CYC) ? ERASE_PROT_CYC : PROG_PROT_CYC;
  localparam int TMR_W  = $clog2(TMAX + 1);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PROG  = 3'd1,
    S_ERASE = 3'd2,
    S_SUSP  = 3'd3,
    S_SPROG = 3'd4,
    S_PPROT = 3'd5,
    S_EPROT = 3'd6
  } st_t;

  st_t              st_q;
  logic             fail_q, t6_q, t2_q, back_susp_q;
  logic [NSECT-1:0] emask_q;
  logic [TMR_W-1:0] tmr_q;

  logic [SECT_W-1:0] prog_sect, rd_sect;
  logic [NSECT-1:0]  erase_eff;
  logic              prog_locked, busy, rd_in_erase, show_status, t2_live;
  logic [DW-1:0]     status_word;

  assign prog_sect   = prog_addr[ADDR_W-1 -: SECT_W];
  assign rd_sect     = rd_addr[ADDR_W-1 -: SECT_W];
  assign prog_locked = prot_mask[prog_sect];
  assign erase_eff   = erase_sel & ~prot_mask;
  assign rd_in_erase = emask_q[rd_sect];

  assign busy = (st_q == S_PROG) || (st_q == S_ERASE) || (st_q == S_SPROG) ||
                (st_q == S_PPROT) || (st_q == S_EPROT);
  assign show_status = busy || (st_q == S_SUSP && rd_in_erase);
  assign t2_live = rd_in_erase && (st_q == S_ERASE || st_q == S_SUSP || st_q == S_SPROG);

  always_comb begin
    status_word    = '0;
    status_word[6] = t6_q;
    status_word[5] = fail_q;
    status_word[2] = t2_q;
  end

  assign rd_data     = show_status ? status_word : array_word;
  assign rb_pull_low = busy;
  assign rb_level    = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      fail_q      <= 1'b0;
      t6_q        <= 1'b0;
      t2_q        <= 1'b0;
      back_susp_q <= 1'b0;
      emask_q     <= '0;
      tmr_q       <= '0;
    end else begin
      if (rd_stb && busy)    t6_q <= ~t6_q;
      if (rd_stb && t2_live) t2_q <= ~t2_q;

      if (st_q == S_PPROT || st_q == S_EPROT) tmr_q <= tmr_q + TMR_W'(1);
      else                                    tmr_q <= '0;

      if (reset_cmd) begin
        st_q    <= S_IDLE;
        fail_q  <= 1'b0;
        emask_q <= '0;
      end else begin
        case (st_q)
          S_IDLE: begin
            if (prog_go) begin
              st_q        <= prog_locked ? S_PPROT : S_PROG;
              back_susp_q <= 1'b0;
            end else if (erase_go && |erase_sel) begin
              emask_q <= erase_eff;
              st_q    <= (|erase_eff) ? S_ERASE : S_EPROT;
            end
          end
          S_PROG: begin
            if (limit_hit)             fail_q <= 1'b1;
            else if (op_done && !fail_q) st_q <= S_IDLE;
          end
          S_ERASE: begin
            if (limit_hit) fail_q <= 1'b1;
            else if (!fail_q && op_done) begin
              st_q    <= S_IDLE;
              emask_q <= '0;
            end else if (!fail_q && suspend_req) st_q <= S_SUSP;
          end
          S_SUSP: begin
            if (resume_req) st_q <= S_ERASE;
            else if (prog_go) begin
              st_q        <= prog_locked ? S_PPROT : S_SPROG;
              back_susp_q <= 1'b1;
            end
          end
          S_SPROG: begin
            if (limit_hit)             fail_q <= 1'b1;
            else if (op_done && !fail_q) st_q <= S_SUSP;
          end
          S_PPROT: begin
            if (tmr_q == TMR_W'(PROG_PROT_CYC - 1))
              st_q <= back_susp_q ? S_SUSP : S_IDLE;
          end
          S_EPROT: begin
            if (tmr_q == TMR_W'(ERASE_PROT_CYC - 1)) st_q <= S_IDLE;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

endmodule

module flash_status_gen_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prog_go,
  input logic          suspend_req,
  input logic          op_done,
  input logic          limit_hit,
  input logic          reset_cmd,
  input logic          rd_stb,
  input logic [DW-1:0] array_word,
  input logic [DW-1:0] rd_data,
  input logic          rb_pull_low,
  input logic [2:0]    st,
  input logic          fail,
  input logic          t6
);

  AST_T6_TOGGLES_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rb_pull_low && $past(rd_stb) && $past(rb_pull_low)) |-> (rd_data[6] != $past(rd_data[6]))); // R2

  AST_T6_FROZEN_IN_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && $past(st) == 3'd3) |-> $stable(t6)); // R3

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !reset_cmd) |=> fail); // R5

  AST_SUSPEND_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_req && st == 3'd2 && !fail && !limit_hit && !op_done && !reset_cmd) |=> !rb_pull_low); // R9

  AST_START_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go && st == 3'd0 && !reset_cmd) |=> rb_pull_low); // R10

  AST_RESET_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (!rb_pull_low && rd_data == array_word)); // R11

endmodule

bind flash_status_gen flash_status_gen_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .suspend_req(suspend_req),
  .op_done(op_done), .limit_hit(limit_hit), .reset_cmd(reset_cmd),
  .rd_stb(rd_stb), .array_word(array_word), .rd_data(rd_data),
  .rb_pull_low(rb_pull_low), .st(st_q), .fail(fail_q), .t6(t6_q)
);

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSECT = 8;
  localparam int ADDR_W = 8;
  localparam int DW = 8;
  localparam int CLK_MHZ = 10;
  localparam int PP = 2 * CLK_MHZ;
  localparam int EP = 100 * CLK_MHZ;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_go = 0, erase_go = 0, suspend_req = 0, resume_req = 0;
  logic op_done = 0, limit_hit = 0, reset_cmd = 0, rd_stb = 0;
  logic [ADDR_W-1:0] prog_addr = '0, rd_addr = '0;
  logic [NSECT-1:0] erase_sel = '0, prot_mask = '0;
  logic [DW-1:0] array_word = '0, rd_data;
  logic rb_pull_low, rb_level;

  flash_status_gen #(.NSECT(NSECT), .ADDR_W(ADDR_W), .DW(DW), .CLK_MHZ(CLK_MHZ)) u_flash_status_gen (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_addr(prog_addr),
    .erase_go(erase_go), .erase_sel(erase_sel), .suspend_req(suspend_req),
    .resume_req(resume_req), .prot_mask(prot_mask), .op_done(op_done),
    .limit_hit(limit_hit), .reset_cmd(reset_cmd), .rd_stb(rd_stb),
    .rd_addr(rd_addr), .array_word(array_word), .rd_data(rd_data),
    .rb_pull_low(rb_pull_low), .rb_level(rb_level));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model: 0 idle 1 prog 2 erase 3 suspend 4 suspended-prog 5/6 lockouts
  int ms = 0;
  bit mfail = 0, mt6 = 0, mt2 = 0, mback = 0;
  logic [NSECT-1:0] mmask = '0;

  function automatic bit m_busy();
    return ms == 1 || ms == 2 || ms == 4 || ms == 5 || ms == 6;
  endfunction

  function automatic logic [DW-1:0] exp_word(logic [ADDR_W-1:0] a, logic [DW-1:0] arr);
    bit sel = mmask[a[ADDR_W-1 -: 3]];
    if (m_busy() || (ms == 3 && sel)) return {1'b0, mt6, mfail, 2'b00, mt2, 2'b00};
    return arr;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rb_chk(string req);
    #1;
    chk(rb_level == !m_busy() && rb_pull_low == m_busy(), req, {6'd0, rb_pull_low, rb_level},
        {6'd0, m_busy(), !m_busy()});
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, string req);
    logic [DW-1:0] e;
    bit sel;
    @(negedge clk);
    rd_stb = 1; rd_addr = a; array_word = DW'($urandom);
    #1;
    e = exp_word(a, array_word);
    chk(rd_data == e, req, rd_data, e);
    sel = mmask[a[ADDR_W-1 -: 3]];
    if (m_busy()) mt6 = ~mt6;
    if (sel && (ms == 2 || ms == 3 || ms == 4)) mt2 = ~mt2;
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic prog(logic [ADDR_W-1:0] a);
    bit locked = prot_mask[a[ADDR_W-1 -: 3]];
    @(negedge clk); prog_go = 1; prog_addr = a;
    if (ms == 0) begin ms = locked ? 5 : 1; mback = 0; end
    else if (ms == 3) begin ms = locked ? 5 : 4; mback = 1; end
    @(negedge clk); prog_go = 0;
  endtask

  task automatic erase(logic [NSECT-1:0] s);
    @(negedge clk); erase_go = 1; erase_sel = s;
    if (ms == 0 && |s) begin mmask = s & ~prot_mask; ms = (|mmask) ? 2 : 6; end
    @(negedge clk); erase_go = 0;
  endtask

  task automatic susp();
    @(negedge clk); suspend_req = 1;
    if (ms == 2 && !mfail) ms = 3;
    @(negedge clk); suspend_req = 0;
  endtask

  task automatic resume();
    @(negedge clk); resume_req = 1;
    if (ms == 3) ms = 2;
    @(negedge clk); resume_req = 0;
  endtask

  task automatic done();
    @(negedge clk); op_done = 1;
    if (!mfail) begin
      if (ms == 1) ms = 0;
      else if (ms == 2) begin ms = 0; mmask = '0; end
      else if (ms == 4) ms = 3;
    end
    @(negedge clk); op_done = 0;
  endtask

  task automatic limit();
    @(negedge clk); limit_hit = 1;
    if (ms == 1 || ms == 2 || ms == 4) mfail = 1;
    @(negedge clk); limit_hit = 0;
  endtask

  task automatic rcmd();
    @(negedge clk); reset_cmd = 1;
    ms = 0; mfail = 0; mmask = '0;
    @(negedge clk); reset_cmd = 0;
  endtask

  task automatic lockout(int n, string req);
    // pulse clear negedge lies between start edge E0 and E1
    repeat (n - 1) @(negedge clk);
    rb_chk(req);
    @(negedge clk);
    ms = mback ? 3 : 0;
    rb_chk(req);
  endtask

  function automatic logic [ADDR_W-1:0] free_addr();
    logic [ADDR_W-1:0] a;
    do a = ADDR_W'($urandom); while (prot_mask[a[ADDR_W-1 -: 3]]);
    return a;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rb_chk("R1");
    rd(8'h12, "R1");
    rd(8'hE7, "R1");

    // R2 / R10: plain program
    prog(8'h10);
    rb_chk("R10");
    rd(8'h10, "R2"); rd(8'h83, "R2"); rd(8'hF0, "R2"); rd(8'h05, "R2");
    done();
    rb_chk("R2");
    rd(8'h10, "R2"); rd(8'h44, "R2");

    // R4 / R3 / R9: erase, suspend, program in suspend
    erase(8'b0000_0110);
    rd(8'h20, "R4"); rd(8'h00, "R4"); rd(8'h41, "R4"); rd(8'hE0, "R4");
    susp();
    rb_chk("R9");
    rd(8'h20, "R3"); rd(8'h22, "R3"); rd(8'h40, "R4"); rd(8'h00, "R4"); rd(8'hA0, "R4");
    prog(8'h01);
    rb_chk("R3");
    rd(8'h01, "R3"); rd(8'h21, "R3"); rd(8'h61, "R3");
    done();
    rb_chk("R3");
    rd(8'h20, "R3"); rd(8'h60, "R4");
    resume();
    rb_chk("R9");
    rd(8'h30, "R4");
    done();
    rd(8'h30, "R2");

    // R8: mixed selection
    prot_mask = 8'b0000_0100;
    erase(8'b0000_0110);
    rd(8'h40, "R8"); rd(8'h45, "R8"); rd(8'h20, "R8"); rd(8'h25, "R8");
    done();

    // R5 / R11: failure is sticky until reset command
    prot_mask = '0;
    prog(8'h70);
    limit();
    rd(8'h70, "R5");
    done();
    rb_chk("R5");
    rd(8'h71, "R5"); rd(8'h72, "R5");
    rcmd();
    rb_chk("R11");
    rd(8'h70, "R11");
    prog(8'h70);
    rd(8'h70, "R11");
    done();

    // R6 / R7: protected lockouts
    prot_mask = 8'b0000_0001;
    prog(8'h03);
    lockout(PP, "R6");
    rd(8'h03, "R6");
    erase(8'b0000_0001);
    lockout(EP, "R7");
    rd(8'h00, "R7");
    prot_mask = 8'b0000_0010;
    erase(8'b0000_0001);
    susp();
    prog(8'h21);
    lockout(PP, "R6");
    rd(8'h00, "R6");

    // R11 from suspend
    rcmd();
    rb_chk("R11");
    rd(8'h00, "R11");

    // random walk
    prot_mask = NSECT'($urandom) & 8'h7F;
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 10;
      case (ms)
        0: if (r < 4) prog(free_addr()); else if (r < 8) erase(NSECT'($urandom) | 8'h80);
           else rd(ADDR_W'($urandom), "R1");
        1, 4: if (r < 5) rd(ADDR_W'($urandom), "R2"); else if (r < 8) done();
              else if (r == 8) limit(); else rcmd();
        2: if (r < 4) rd(ADDR_W'($urandom), "R4"); else if (r < 6) susp();
           else if (r < 8) done(); else if (r == 8) limit(); else rcmd();
        3: if (r < 4) rd(ADDR_W'($urandom), "R3"); else if (r < 6) resume();
           else if (r < 8) prog(free_addr()); else rcmd();
        default: rcmd();
      endcase
      if (i % 50 == 49) rb_chk("R9");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule